// File: doc/BRIEF.md
# Reconfigurable LUT Logic Cell

This block models one programmable logic cell with two identical 16-entry function generators. Each generator feeds one storage element. A static mode input sets each generator to act as a 4-input lookup table, as a 16-stage shift register with an addressable tap, or as a 16x1 RAM with synchronous write and asynchronous read. The table, register or RAM contents are one 16-bit store per generator. That store is filled through a serial configuration chain that runs through both generators. Generator 0 comes first in the chain.

Each storage element can be set to act as a rising-edge D flip-flop or as a latch that is transparent while the clock is high. A per-output select drives either the stored value or the raw generator value onto the output. The shift-data and write-data inputs have no valid/ready handshake. A bit is taken on any rising edge where its enable is high, and the cell never applies back-pressure. All mode, latch and select inputs are plain control pins.

Top module: `lut_cell_top`

## Requirements
- R1: While rst_n is low, all contents, flip-flops and latches clear to 0, so every output is 0 after reset.
- R2: On each rising edge with cfg_en_i high, cfg_din_i enters bit 0 of generator 0. Each generator's bits move up by one, and bit 15 of generator 0 enters bit 0 of generator 1. This takes priority over any shift or write.
- R3: Mode code 0 (and the unused code 3) is lookup mode. fg_comb_o equals content bit fg_addr_i, and fg_we_i has no effect on the content.
- R4: Mode code 1 is shift mode. On a rising edge with fg_we_i high, the content becomes {content[14:0], fg_din_i}. With fg_we_i low it holds. fg_comb_o is content bit fg_addr_i.
- R5: Mode code 2 is RAM mode. On a rising edge with fg_we_i high, content bit fg_addr_i takes fg_din_i. The read output fg_comb_o = content[fg_addr_i] shows the new bit straight after that edge.
- R6: With fg_latch_i = 0, the storage element captures fg_comb_o on each rising clock edge.
- R7: With fg_latch_i = 1, the storage element follows fg_comb_o while clk is high and holds the value it had when clk fell while clk is low.
- R8: fg_out_o is the storage element value when fg_regsel_i = 1 and fg_comb_o when fg_regsel_i = 0.
- R9: The two generators work independently. Index 0 and index 1 may sit in different modes and different storage settings at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the latch gate |
| rst_n | input | 1 | Active-low reset |
| cfg_en_i | input | 1 | Serial configuration shift enable |
| cfg_din_i | input | 1 | Serial configuration data |
| fg_mode_i | input | 2x2 | Per-generator mode: 0 lookup, 1 shift, 2 RAM, 3 lookup |
| fg_latch_i | input | 2 | Per storage element: 1 latch, 0 flip-flop |
| fg_regsel_i | input | 2 | Per output: 1 stored value, 0 combinational |
| fg_addr_i | input | 2x4 | Per-generator lookup / tap / RAM address |
| fg_din_i | input | 2 | Per-generator shift or write data |
| fg_we_i | input | 2 | Per-generator shift or write enable |
| fg_comb_o | output | 2 | Combinational generator outputs |
| fg_out_o | output | 2 | Selected outputs |

## Verification
The bench goes after several corner cases, and each bug shows up as a distinct failure.

- Chain hand-off from bit 15 of the first generator into the second: a break or reversal there gives wrong lookup values on every address of generator 1.
- A write in RAM mode read back in the very next cycle at the same address: a registered read path would return the old bit.
- Configuration shifting while a write enable is also high: the wrong priority corrupts a single addressed bit instead of moving the chain.
- The latch phase after its input has changed while clk is low: a latch that stays transparent, or that acts as a flip-flop, shows the new value early or the old value too long.
- Write pulses in lookup mode must leave the table alone.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
  typedef enum logic [1:0] {
    FG_LOOKUP = 2'd0,
    FG_SHIFT  = 2'd1,
    FG_RAM    = 2'd2,
    FG_SPARE  = 2'd3
  } fg_mode_e;
endpackage

// File: rtl/lut_cell_fgen.sv
module lut_cell_fgen
  import lut_cell_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              cfg_en_i,
  input  logic              cfg_in_i,
  output logic              cfg_out_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              din_i,
  input  logic              we_i,
  output logic              rd_o
);
  logic [DEPTH-1:0] store_q;
  logic [DEPTH-1:0] store_nxt;

  always_comb begin
    store_nxt = store_q;
    if (cfg_en_i) begin
      store_nxt = {store_q[DEPTH-2:0], cfg_in_i};
    end else if (we_i) begin
      case (mode_i)
        FG_SHIFT: store_nxt = {store_q[DEPTH-2:0], din_i};
        FG_RAM:   store_nxt[addr_i] = din_i;
        default:  store_nxt = store_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) store_q <= '0;
    else        store_q <= store_nxt;
  end

  assign rd_o      = store_q[addr_i];
  assign cfg_out_o = store_q[DEPTH-1];

  // R2
  cfg_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en_i |=> (store_q == {$past(store_q[DEPTH-2:0]), $past(cfg_in_i)}));

  // R3
  lookup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en_i && (mode_i == FG_LOOKUP || mode_i == FG_SPARE)) |=> $stable(store_q));

  // R4
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en_i && we_i && mode_i == FG_SHIFT) |=> (store_q[0] == $past(din_i)));

  // R5
  ram_rdnew_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en_i && we_i && mode_i == FG_RAM) |=>
      ((addr_i != $past(addr_i)) || (rd_o == $past(din_i))));
endmodule

// File: rtl/lut_cell_store.sv
module lut_cell_store (
  input  logic clk,
  input  logic rst_n,
  input  logic latch_mode_i,
  input  logic d_i,
  output logic q_o
);
  logic edge_q;
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_q <= 1'b0;
    else        edge_q <= d_i;
  end

  always_latch begin
    if (!rst_n)   lvl_q <= 1'b0;
    else if (clk) lvl_q <= d_i;
  end

  assign q_o = latch_mode_i ? lvl_q : edge_q;

  // R6
  ff_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_mode_i && !$past(latch_mode_i)) |=> (edge_q == $past(d_i)));

  // R7
  latch_open_chk: assert property (@(negedge clk) disable iff (!rst_n)
    latch_mode_i |-> (q_o == d_i));
endmodule

// File: rtl/lut_cell_top.sv
module lut_cell_top
  import lut_cell_pkg::*;
#(
  parameter int NUM_FG = 2,
  parameter int ADDR_W = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_en_i,
  input  logic                           cfg_din_i,
  input  logic [NUM_FG-1:0][1:0]         fg_mode_i,
  input  logic [NUM_FG-1:0]              fg_latch_i,
  input  logic [NUM_FG-1:0]              fg_regsel_i,
  input  logic [NUM_FG-1:0][ADDR_W-1:0]  fg_addr_i,
  input  logic [NUM_FG-1:0]              fg_din_i,
  input  logic [NUM_FG-1:0]              fg_we_i,
  output logic [NUM_FG-1:0]              fg_comb_o,
  output logic [NUM_FG-1:0]              fg_out_o
);
  logic [NUM_FG:0]   chain;
  logic [NUM_FG-1:0] stored;

  assign chain[0] = cfg_din_i;

  for (genvar k = 0; k < NUM_FG; k++) begin : g_slice
    lut_cell_fgen #(.ADDR_W(ADDR_W)) fgen_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_i    (fg_mode_i[k]),
      .cfg_en_i  (cfg_en_i),
      .cfg_in_i  (chain[k]),
      .cfg_out_o (chain[k+1]),
      .addr_i    (fg_addr_i[k]),
      .din_i     (fg_din_i[k]),
      .we_i      (fg_we_i[k]),
      .rd_o      (fg_comb_o[k])
    );

    lut_cell_store store_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .latch_mode_i (fg_latch_i[k]),
      .d_i          (fg_comb_o[k]),
      .q_o          (stored[k])
    );

    assign fg_out_o[k] = fg_regsel_i[k] ? stored[k] : fg_comb_o[k];
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!rst_n || (fg_comb_o == '0)));
endmodule

// File: tb/lut_cell_top_tb_top.sv
module lut_cell_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0, cfg_din = 1'b0;
  logic [1:0][1:0] mode = '0;
  logic [1:0] latch_s = '0, regsel = '0, din = '0, we = '0;
  logic [1:0][3:0] addr = '0;
  logic [1:0] comb_o, out_o;

  logic s_cfg_en, s_cfg_din;
  logic [1:0][1:0] s_mode;
  logic [1:0] s_latch, s_regsel, s_din, s_we;
  logic [1:0][3:0] s_addr;

  logic [15:0] m_mem [2];
  logic m_ff [2];
  logic m_lat [2];
  int total = 0, bad = 0;
  bit done = 0;
  string cur_tag = "R3";

  always #4 clk = ~clk;

  lut_cell_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en_i(cfg_en), .cfg_din_i(cfg_din),
    .fg_mode_i(mode), .fg_latch_i(latch_s), .fg_regsel_i(regsel),
    .fg_addr_i(addr), .fg_din_i(din), .fg_we_i(we),
    .fg_comb_o(comb_o), .fg_out_o(out_o)
  );

  function automatic logic m_comb(int i);
    return m_mem[i][addr[i]];
  endfunction

  function automatic logic m_out(int i, logic stored);
    return regsel[i] ? stored : m_comb(i);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  function automatic string out_tag(int i);
    if (!regsel[i]) return "R8";
    return latch_s[i] ? "R7" : "R6";
  endfunction

  task automatic stage_idle();
    s_cfg_en = 0; s_cfg_din = 0; s_mode = mode; s_latch = latch_s;
    s_regsel = regsel; s_din = 0; s_we = 0; s_addr = addr;
  endtask

  task automatic step();
    logic d_pre [2];
    logic [15:0] n0, n1;
    @(negedge clk);
    for (int i = 0; i < 2; i++) m_lat[i] = m_comb(i);
    #1;
    cfg_en = s_cfg_en; cfg_din = s_cfg_din; mode = s_mode; latch_s = s_latch;
    regsel = s_regsel; din = s_din; we = s_we; addr = s_addr;
    #1;
    for (int i = 0; i < 2; i++) begin
      chk(cur_tag, comb_o[i], m_comb(i));
      chk(out_tag(i), out_o[i], m_out(i, latch_s[i] ? m_lat[i] : m_ff[i]));
      d_pre[i] = m_comb(i);
    end
    @(posedge clk);
    if (cfg_en) begin
      n0 = {m_mem[0][14:0], cfg_din};
      n1 = {m_mem[1][14:0], m_mem[0][15]};
      m_mem[0] = n0; m_mem[1] = n1;
    end else begin
      for (int i = 0; i < 2; i++)
        if (we[i]) begin
          if (mode[i] == 2'd1) m_mem[i] = {m_mem[i][14:0], din[i]};
          else if (mode[i] == 2'd2) m_mem[i][addr[i]] = din[i];
        end
    end
    for (int i = 0; i < 2; i++) m_ff[i] = d_pre[i];
    #1;
    for (int i = 0; i < 2; i++) begin
      chk(cur_tag, comb_o[i], m_comb(i));
      chk(out_tag(i), out_o[i], m_out(i, latch_s[i] ? m_comb(i) : m_ff[i]));
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 2; i++) begin m_mem[i] = '0; m_ff[i] = 0; m_lat[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: everything clear after reset, both output paths
    regsel = 2'b11;
    #1;
    chk("R1", comb_o[0], 1'b0); chk("R1", comb_o[1], 1'b0);
    chk("R1", out_o[0], 1'b0);  chk("R1", out_o[1], 1'b0);
    rst_n = 1;

    // R2: load 32 random bits through the chain
    cur_tag = "R2";
    for (int b = 0; b < 32; b++) begin
      stage_idle(); s_cfg_en = 1; s_cfg_din = 1'($urandom);
      s_we = 2'b11; s_din = 2'($urandom); s_mode = {2'd2, 2'd1};
      step();
    end
    // R3: sweep lookup addresses, with write pulses that must not alter content
    cur_tag = "R3";
    for (int a = 0; a < 16; a++) begin
      stage_idle(); s_mode = {2'd3, 2'd0}; s_regsel = 2'b00;
      s_addr = {4'(15 - a), 4'(a)}; s_we = 2'b11; s_din = 2'($urandom);
      step();
    end

    // R4: shift with enable low holds, then shifts
    cur_tag = "R4";
    for (int n = 0; n < 24; n++) begin
      stage_idle(); s_mode = {2'd1, 2'd1}; s_we = (n < 4) ? 2'b00 : 2'($urandom);
      s_din = 2'($urandom); s_addr = {4'($urandom), 4'($urandom)}; s_regsel = 2'b11;
      step();
    end

    // R5: directed write then immediate same-address read on generator 1
    cur_tag = "R5";
    stage_idle(); s_mode = {2'd2, 2'd0}; s_addr[1] = 4'd5; s_we = 2'b10;
    s_din[1] = ~m_mem[1][5];
    step();
    chk("R5", comb_o[1], s_din[1]);
    for (int n = 0; n < 24; n++) begin
      stage_idle(); s_mode = {2'd2, 2'd2}; s_we = 2'($urandom); s_din = 2'($urandom);
      s_addr = {4'($urandom % 4), 4'($urandom % 4)}; s_regsel = 2'($urandom);
      step();
    end

    // R6 / R7: flip-flop versus latch, address changing every cycle
    cur_tag = "R6";
    for (int n = 0; n < 40; n++) begin
      stage_idle(); s_mode = {2'd0, 2'd0}; s_regsel = 2'b11;
      s_latch = (n < 20) ? 2'b00 : 2'b11; s_addr = {4'($urandom), 4'($urandom)};
      if (n >= 20) cur_tag = "R7";
      step();
    end

    // R9: random mixed traffic, modes differ per generator
    cur_tag = "R9";
    for (int n = 0; n < 600; n++) begin
      stage_idle();
      if (n % 40 == 0) begin
        s_mode = {2'($urandom), 2'($urandom)};
        s_latch = 2'($urandom);
      end
      s_cfg_en = ($urandom % 16) == 0; s_cfg_din = 1'($urandom);
      s_we = 2'($urandom); s_din = 2'($urandom);
      s_addr = {4'($urandom), 4'($urandom)}; s_regsel = 2'($urandom);
      step();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule